// File: doc/BRIEF.md
# Eight-Word Instruction Loop Buffer

This block sits between an instruction fetch stage and instruction memory. It keeps the eight instruction words fetched most recently, and each word is tagged with the address it was read from. The fetch stage presents one address per request. If a valid entry already carries that address, the buffer returns the word on the next cycle and memory is not touched. If no entry matches, the buffer sends one request to memory and waits for the response handshake. It then returns the word and shifts it in as the newest entry, and the oldest entry drops out of the window.

Sequential fetches and conditional jumps look the same to the buffer: each is a plain lookup. A small loop closed by a conditional jump therefore runs entirely out of the window once it has been fetched once. An unconditional jump is marked on its request. That mark clears every entry before the lookup is resolved, so the jump target itself is always fetched from memory. Two free-running counters give the number of lookups served from the window and the number sent to memory.

Top module: `loop_buf`

## Requirements
- R1: After reset all entries are invalid, `ready` is 1, `rsp_valid` and `mem_req_valid` are 0, and both counters read 0. Reset assertion is asynchronous, and its release takes effect two clock edges later.
- R2: When an accepted lookup (`req_valid` and `ready` both 1 at a clock edge) matches a valid entry and `req_uncond` is 0, `rsp_valid` is 1 with `rsp_hit` 1 and the stored word on the cycle after acceptance, and no memory request is made.
- R3: When an accepted lookup matches no valid entry, `mem_req_valid` rises on the next cycle with `mem_req_addr` equal to the requested address. The word from `mem_rsp_data` is returned with `rsp_hit` 0 on the cycle after `mem_rsp_valid` is seen.
- R4: The window holds eight distinct addresses. Each miss inserts its word as the newest entry and evicts the oldest one, so the ninth distinct miss removes the first address while the other eight still hit.
- R5: An accepted lookup with `req_uncond` 1 invalidates every entry, so any address held before it misses afterwards.
- R6: The flush from an unconditional request is applied before its own lookup, so that request is a miss even when its target was held.
- R7: A lookup with `req_uncond` 0, whether sequential or a conditional jump, leaves all entries valid. A loop re-entered this way hits on every word.
- R8: `hit_count` increases by one for each accepted hit and `miss_count` by one for each accepted miss.
- R9: While a miss is outstanding, `ready` is 0 and `req_valid` is ignored: no extra response and no change to the memory address.
- R10: `mem_req_addr` stays stable while `mem_req_valid` is held waiting for the response.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Fetch request present |
| req_addr | input | AW (18) | Fetch address |
| req_uncond | input | 1 | Request is an unconditional jump: flush first |
| ready | output | 1 | Buffer can accept a request |
| rsp_valid | output | 1 | Returned word valid (one cycle) |
| rsp_data | output | DW (60) | Returned instruction word |
| rsp_hit | output | 1 | 1 if served from the window, 0 if from memory |
| mem_req_valid | output | 1 | Memory read request, held until response |
| mem_req_addr | output | AW (18) | Memory read address |
| mem_rsp_valid | input | 1 | Memory response handshake |
| mem_rsp_data | input | DW (60) | Memory read data |
| hit_count | output | CW (16) | Accepted lookups served by the window |
| miss_count | output | CW (16) | Accepted lookups sent to memory |

## Verification
Two of the block's functions can fall in the same cycle: the flush caused by an unconditional jump, and the tag lookup for that jump's own target. The bench provokes this by issuing an unconditional jump to an address known to be held in the window. It then judges the outcome at the ports. The jump must cause exactly one memory access and return with `rsp_hit` 0. A formerly held neighbour must miss afterwards. The jump target, which was re-inserted by the miss, must hit on a later plain lookup.

// File: rtl/lb_pkg.sv
package lb_pkg;
  typedef enum logic [0:0] {
    LB_IDLE = 1'b0,
    LB_WAIT = 1'b1
  } lb_state_e;
endpackage

// File: rtl/lb_window.sv
module lb_window #(
  parameter int DEPTH = 8,
  parameter int AW    = 18,
  parameter int DW    = 60
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             shift_en,
  input  logic [AW-1:0]    in_addr,
  input  logic [DW-1:0]    in_word,
  output logic [AW-1:0]    tag_o  [DEPTH],
  output logic [DW-1:0]    word_o [DEPTH],
  output logic [DEPTH-1:0] valid_o
);
  logic [DEPTH-1:0] valid_q, valid_d;
  logic [AW-1:0]    tag_q  [DEPTH];
  logic [DW-1:0]    word_q [DEPTH];
  logic [AW-1:0]    tag_d  [DEPTH];
  logic [DW-1:0]    word_d [DEPTH];

  // valid bits: flush clears first, a shift then marks the newest slot
  always_comb begin
    valid_d = valid_q;
    if (flush)    valid_d = '0;
    if (shift_en) valid_d = {valid_d[DEPTH-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) valid_q <= '0;
    else        valid_q <= valid_d;
  end

  // slot 0 holds the newest word, slot DEPTH-1 the oldest
  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    if (i == 0) begin : g_head
      always_comb begin
        tag_d[i]  = in_addr;
        word_d[i] = in_word;
      end
    end else begin : g_body
      always_comb begin
        tag_d[i]  = tag_q[i-1];
        word_d[i] = word_q[i-1];
      end
    end

    always_ff @(posedge clk) begin
      if (shift_en) begin
        tag_q[i]  <= tag_d[i];
        word_q[i] <= word_d[i];
      end
    end

    assign tag_o[i]  = tag_q[i];
    assign word_o[i] = word_q[i];
  end

  assign valid_o = valid_q;
endmodule

// File: rtl/lb_match.sv
module lb_match #(
  parameter int DEPTH = 8,
  parameter int AW    = 18,
  parameter int DW    = 60
) (
  input  logic [AW-1:0]    addr,
  input  logic [AW-1:0]    tag_i  [DEPTH],
  input  logic [DW-1:0]    word_i [DEPTH],
  input  logic [DEPTH-1:0] valid_i,
  output logic [DEPTH-1:0] hit_vec,
  output logic             hit,
  output logic [DW-1:0]    hit_word
);
  for (genvar i = 0; i < DEPTH; i++) begin : g_cmp
    assign hit_vec[i] = valid_i[i] && (tag_i[i] == addr);
  end

  // entries are unique, so an AND-OR mux needs no priority
  always_comb begin
    hit_word = '0;
    for (int i = 0; i < DEPTH; i++) begin
      hit_word = hit_word | (word_i[i] & {DW{hit_vec[i]}});
    end
  end

  assign hit = |hit_vec;
endmodule

// File: rtl/lb_ctrl.sv
module lb_ctrl
  import lb_pkg::*;
#(
  parameter int AW = 18,
  parameter int DW = 60,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic [AW-1:0] req_addr,
  input  logic          req_uncond,
  input  logic          lookup_hit,
  input  logic [DW-1:0] lookup_word,
  input  logic          mem_rsp_valid,
  input  logic [DW-1:0] mem_rsp_data,
  output logic          ready,
  output logic          accept,
  output logic          flush,
  output logic          shift_en,
  output logic [AW-1:0] ins_addr,
  output logic [DW-1:0] ins_word,
  output logic          mem_req_valid,
  output logic [AW-1:0] mem_req_addr,
  output logic          rsp_valid,
  output logic [DW-1:0] rsp_data,
  output logic          rsp_hit,
  output logic [CW-1:0] hit_count,
  output logic [CW-1:0] miss_count
);
  lb_state_e     state_q, state_d;
  logic [AW-1:0] pend_q, pend_d;
  logic          pend_en;
  logic          rsp_v_q, rsp_v_d;
  logic [DW-1:0] rsp_data_q, rsp_data_d;
  logic          rsp_hit_q, rsp_hit_d;
  logic          rsp_en;
  logic [CW-1:0] hit_q, hit_d, miss_q, miss_d;
  logic          eff_hit;

  assign ready   = (state_q == LB_IDLE);
  assign accept  = ready && req_valid;
  assign flush   = accept && req_uncond;
  assign eff_hit = lookup_hit && !req_uncond;

  always_comb begin
    state_d    = state_q;
    pend_d     = pend_q;
    pend_en    = 1'b0;
    rsp_v_d    = 1'b0;
    rsp_data_d = rsp_data_q;
    rsp_hit_d  = rsp_hit_q;
    rsp_en     = 1'b0;
    hit_d      = hit_q;
    miss_d     = miss_q;
    shift_en   = 1'b0;
    unique case (state_q)
      LB_IDLE: begin
        if (accept) begin
          if (eff_hit) begin
            rsp_v_d    = 1'b1;
            rsp_data_d = lookup_word;
            rsp_hit_d  = 1'b1;
            rsp_en     = 1'b1;
            hit_d      = hit_q + CW'(1);
          end else begin
            state_d = LB_WAIT;
            pend_d  = req_addr;
            pend_en = 1'b1;
            miss_d  = miss_q + CW'(1);
          end
        end
      end
      LB_WAIT: begin
        if (mem_rsp_valid) begin
          shift_en   = 1'b1;
          rsp_v_d    = 1'b1;
          rsp_data_d = mem_rsp_data;
          rsp_hit_d  = 1'b0;
          rsp_en     = 1'b1;
          state_d    = LB_IDLE;
        end
      end
      default: state_d = LB_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= LB_IDLE;
      rsp_v_q <= 1'b0;
      hit_q   <= '0;
      miss_q  <= '0;
    end else begin
      state_q <= state_d;
      rsp_v_q <= rsp_v_d;
      hit_q   <= hit_d;
      miss_q  <= miss_d;
    end
  end

  always_ff @(posedge clk) begin
    if (pend_en) pend_q <= pend_d;
    if (rsp_en) begin
      rsp_data_q <= rsp_data_d;
      rsp_hit_q  <= rsp_hit_d;
    end
  end

  assign ins_addr      = pend_q;
  assign ins_word      = mem_rsp_data;
  assign mem_req_valid = (state_q == LB_WAIT);
  assign mem_req_addr  = pend_q;
  assign rsp_valid     = rsp_v_q;
  assign rsp_data      = rsp_data_q;
  assign rsp_hit       = rsp_hit_q;
  assign hit_count     = hit_q;
  assign miss_count    = miss_q;
endmodule

// File: rtl/loop_buf.sv
module loop_buf #(
  parameter int DEPTH = 8,
  parameter int AW    = 18,
  parameter int DW    = 60,
  parameter int CW    = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic [AW-1:0] req_addr,
  input  logic          req_uncond,
  output logic          ready,
  output logic          rsp_valid,
  output logic [DW-1:0] rsp_data,
  output logic          rsp_hit,
  output logic          mem_req_valid,
  output logic [AW-1:0] mem_req_addr,
  input  logic          mem_rsp_valid,
  input  logic [DW-1:0] mem_rsp_data,
  output logic [CW-1:0] hit_count,
  output logic [CW-1:0] miss_count
);
  localparam int SYNC_STAGES = 2;

  logic [SYNC_STAGES-1:0] rst_sync;
  logic                   rst_q;
  logic [AW-1:0]          tags  [DEPTH];
  logic [DW-1:0]          words [DEPTH];
  logic [DEPTH-1:0]       valid_vec;
  logic [DEPTH-1:0]       hit_vec;
  logic                   lookup_hit;
  logic [DW-1:0]          lookup_word;
  logic                   accept, flush, shift_en;
  logic [AW-1:0]          ins_addr;
  logic [DW-1:0]          ins_word;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= '0;
    else        rst_sync <= {rst_sync[SYNC_STAGES-2:0], 1'b1};
  end
  assign rst_q = rst_sync[SYNC_STAGES-1];

  lb_window #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) u_window (
    .clk      (clk),
    .rst_n    (rst_q),
    .flush    (flush),
    .shift_en (shift_en),
    .in_addr  (ins_addr),
    .in_word  (ins_word),
    .tag_o    (tags),
    .word_o   (words),
    .valid_o  (valid_vec)
  );

  lb_match #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) u_match (
    .addr     (req_addr),
    .tag_i    (tags),
    .word_i   (words),
    .valid_i  (valid_vec),
    .hit_vec  (hit_vec),
    .hit      (lookup_hit),
    .hit_word (lookup_word)
  );

  lb_ctrl #(.AW(AW), .DW(DW), .CW(CW)) u_ctrl (
    .clk           (clk),
    .rst_n         (rst_q),
    .req_valid     (req_valid),
    .req_addr      (req_addr),
    .req_uncond    (req_uncond),
    .lookup_hit    (lookup_hit),
    .lookup_word   (lookup_word),
    .mem_rsp_valid (mem_rsp_valid),
    .mem_rsp_data  (mem_rsp_data),
    .ready         (ready),
    .accept        (accept),
    .flush         (flush),
    .shift_en      (shift_en),
    .ins_addr      (ins_addr),
    .ins_word      (ins_word),
    .mem_req_valid (mem_req_valid),
    .mem_req_addr  (mem_req_addr),
    .rsp_valid     (rsp_valid),
    .rsp_data      (rsp_data),
    .rsp_hit       (rsp_hit),
    .hit_count     (hit_count),
    .miss_count    (miss_count)
  );
endmodule

// File: rtl/lb_checker.sv
module lb_checker #(
  parameter int DEPTH = 8,
  parameter int AW    = 18,
  parameter int DW    = 60,
  parameter int CW    = 16
) (
  input logic             clk,
  input logic             rst_q,
  input logic             req_valid,
  input logic [AW-1:0]    req_addr,
  input logic             req_uncond,
  input logic             ready,
  input logic             rsp_valid,
  input logic             rsp_hit,
  input logic             mem_req_valid,
  input logic [AW-1:0]    mem_req_addr,
  input logic             mem_rsp_valid,
  input logic [CW-1:0]    hit_count,
  input logic [CW-1:0]    miss_count,
  input logic             lookup_hit,
  input logic [DEPTH-1:0] hit_vec,
  input logic [DEPTH-1:0] valid_vec
);
  logic acc;
  assign acc = req_valid && ready;

  AST_RESET_IDLE: assert property (@(posedge clk) $rose(rst_q) |-> ready && !mem_req_valid && !rsp_valid); // R1
  AST_HIT_FAST: assert property (@(posedge clk) disable iff (!rst_q) (acc && lookup_hit && !req_uncond) |=> (rsp_valid && rsp_hit && !mem_req_valid)); // R2
  AST_MISS_REQ: assert property (@(posedge clk) disable iff (!rst_q) (acc && !lookup_hit) |=> (mem_req_valid && mem_req_addr == $past(req_addr))); // R3
  AST_UNIQUE_TAGS: assert property (@(posedge clk) disable iff (!rst_q) $onehot0(hit_vec)); // R4
  AST_FLUSH_CLEARS: assert property (@(posedge clk) disable iff (!rst_q) (acc && req_uncond) |=> ($countones(valid_vec) == 0)); // R5
  AST_FLUSH_MISSES: assert property (@(posedge clk) disable iff (!rst_q) (acc && req_uncond) |=> (mem_req_valid && !rsp_valid)); // R6
  AST_PLAIN_KEEPS: assert property (@(posedge clk) disable iff (!rst_q) (acc && !req_uncond) |=> ($countones(valid_vec) >= $countones($past(valid_vec)))); // R7
  AST_HIT_COUNT: assert property (@(posedge clk) disable iff (!rst_q) (acc && lookup_hit && !req_uncond) |=> (hit_count == $past(hit_count) + CW'(1) && $stable(miss_count))); // R8
  AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_q) mem_req_valid |-> !ready); // R9
  AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_q) (mem_req_valid && !mem_rsp_valid) |=> (mem_req_valid && $stable(mem_req_addr))); // R10
endmodule

bind loop_buf lb_checker #(.DEPTH(DEPTH), .AW(AW), .DW(DW), .CW(CW)) u_lb_checker (
  .clk           (clk),
  .rst_q         (rst_q),
  .req_valid     (req_valid),
  .req_addr      (req_addr),
  .req_uncond    (req_uncond),
  .ready         (ready),
  .rsp_valid     (rsp_valid),
  .rsp_hit       (rsp_hit),
  .mem_req_valid (mem_req_valid),
  .mem_req_addr  (mem_req_addr),
  .mem_rsp_valid (mem_rsp_valid),
  .hit_count     (hit_count),
  .miss_count    (miss_count),
  .lookup_hit    (lookup_hit),
  .hit_vec       (hit_vec),
  .valid_vec     (valid_vec)
);

// File: tb/sim_loop_buf.sv
`timescale 1ns/1ps
module sim_loop_buf;
  localparam int AW  = 18;
  localparam int DW  = 60;
  localparam int CW  = 16;
  localparam int LAT = 3;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          req_valid, req_uncond;
  logic [AW-1:0] req_addr;
  logic          ready, rsp_valid, rsp_hit, mem_req_valid;
  logic [DW-1:0] rsp_data;
  logic [AW-1:0] mem_req_addr;
  logic          mem_rsp_valid;
  logic [DW-1:0] mem_rsp_data;
  logic [CW-1:0] hit_count, miss_count;

  int checks = 0;
  int fails  = 0;
  int mem_acc = 0;
  int mem_wait = 0;

  always #2 clk = ~clk;

  loop_buf #(.DEPTH(8), .AW(AW), .DW(DW), .CW(CW)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
    .req_uncond(req_uncond), .ready(ready), .rsp_valid(rsp_valid),
    .rsp_data(rsp_data), .rsp_hit(rsp_hit), .mem_req_valid(mem_req_valid),
    .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_data(mem_rsp_data), .hit_count(hit_count), .miss_count(miss_count)
  );

  function automatic logic [DW-1:0] mem_word(input logic [AW-1:0] a);
    return {6'h2A, a, a ^ 18'h15555, a + 18'd7};
  endfunction

  // memory model: answers LAT cycles after a held request, one-cycle handshake
  always @(negedge clk) begin
    if (mem_rsp_valid) begin
      mem_rsp_valid <= 1'b0;
    end else if (mem_req_valid && rst_n) begin
      if (mem_wait == LAT - 1) begin
        mem_wait      <= 0;
        mem_rsp_valid <= 1'b1;
        mem_rsp_data  <= mem_word(mem_req_addr);
        mem_acc       <= mem_acc + 1;
      end else begin
        mem_wait <= mem_wait + 1;
      end
    end
  end

  task automatic check(input bit ok, input string rq, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
    end
  endtask

  task automatic fetch(input logic [AW-1:0] a, input logic unc,
                       input logic exp_hit, input string rq);
    int m0;
    int n;
    m0 = mem_acc;
    n  = 0;
    while (!ready) @(negedge clk);
    req_valid  = 1'b1;
    req_addr   = a;
    req_uncond = unc;
    @(negedge clk);
    req_valid  = 1'b0;
    req_uncond = 1'b0;
    if (exp_hit) begin
      check(rsp_valid === 1'b1, rq, "hit response next cycle", 64'(rsp_valid), 64'd1);
    end else begin
      check(!ready && mem_req_valid && mem_req_addr == a, rq, "miss request address",
            64'(mem_req_addr), 64'(a));
    end
    while (!rsp_valid && n < 50) begin
      @(negedge clk);
      n++;
    end
    check(rsp_hit === exp_hit, rq, "rsp_hit", 64'(rsp_hit), 64'(exp_hit));
    check(rsp_data === mem_word(a), rq, "rsp_data", 64'(rsp_data), 64'(mem_word(a)));
    check(mem_acc - m0 == (exp_hit ? 0 : 1), rq, "memory accesses",
          64'(mem_acc - m0), exp_hit ? 64'd0 : 64'd1);
    @(negedge clk);
  endtask

  task automatic t_reset();
    check(ready === 1'b1 && rsp_valid === 1'b0 && mem_req_valid === 1'b0, "R1",
          "idle outputs", {61'd0, ready, rsp_valid, mem_req_valid}, 64'd4);
    check(hit_count == 0 && miss_count == 0, "R1", "counters",
          {32'(hit_count), 32'(miss_count)}, 64'd0);
  endtask

  task automatic t_fill();
    for (int i = 0; i < 8; i++) fetch(18'h100 + 18'(i), 1'b0, 1'b0, "R3");
  endtask

  task automatic t_loop_cond();
    for (int i = 0; i < 8; i++) fetch(18'h100 + 18'(i), 1'b0, 1'b1, "R7");
    check(hit_count == 8 && miss_count == 8, "R8", "hit/miss counts",
          {32'(hit_count), 32'(miss_count)}, {32'd8, 32'd8});
  endtask

  task automatic t_evict();
    fetch(18'h108, 1'b0, 1'b0, "R4");
    fetch(18'h101, 1'b0, 1'b1, "R4");
    fetch(18'h100, 1'b0, 1'b0, "R4");
  endtask

  task automatic t_busy_ignore();
    logic [CW-1:0] h0, m0;
    int resp_seen;
    h0 = hit_count;
    m0 = miss_count;
    resp_seen = 0;
    req_valid = 1'b1; req_addr = 18'h200; req_uncond = 1'b0;
    @(negedge clk);
    req_addr = 18'h101;
    @(negedge clk);
    req_valid = 1'b0;
    check(mem_req_addr == 18'h200 && !ready, "R9", "address during stray request",
          64'(mem_req_addr), 64'h200);
    for (int k = 0; k < 10; k++) begin
      if (rsp_valid) resp_seen++;
      @(negedge clk);
    end
    check(resp_seen == 1, "R9", "responses for one miss", 64'(resp_seen), 64'd1);
    check(hit_count == h0 && miss_count == m0 + CW'(1), "R9", "counters after stray",
          {32'(hit_count), 32'(miss_count)}, {32'(h0), 32'(m0 + CW'(1))});
    check(rsp_data === mem_word(18'h200), "R10", "word of held address",
          64'(rsp_data), 64'(mem_word(18'h200)));
  endtask

  task automatic t_flush();
    fetch(18'h105, 1'b0, 1'b1, "R2");
    fetch(18'h104, 1'b1, 1'b0, "R6");
    fetch(18'h105, 1'b0, 1'b0, "R5");
    fetch(18'h104, 1'b0, 1'b1, "R7");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_uncond = 1'b0; req_addr = '0;
    mem_rsp_valid = 1'b0; mem_rsp_data = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_fill();
    t_loop_cond();
    t_evict();
    t_busy_ignore();
    t_flush();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule